// File: doc/BRIEF.md
# Quiet and Signaling Float Comparator

This block compares two IEEE 754 single-precision operands and reports the outcome as four condition flags: negative, zero, carry and overflow. A processor pipeline uses them to drive its conditional execution. Each comparison is requested by a one-cycle valid strobe. The flags, the result-valid bit and an optional exception pulse are all registered, and they appear on the clock edge that follows the strobe. A new comparison may start on every cycle.

A select bit chooses one of two compare flavours. The quiet flavour reports every outcome, including the unordered outcome, without ever raising an exception. The signaling flavour gives the same flags. In addition, it pulses an invalid-operation output whenever either operand is a NaN. An unordered result has its own flag, the overflow flag, so the consumer can tell it apart from an ordered outcome.

The flag encoding is the following. A less-than result sets only N. An equal result sets Z and C. A greater-than result sets only C. An unordered result sets C and V. Positive zero and negative zero compare equal. Infinities are ordered values.

Top module: `fcmp_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe yet seen, `resValid`, `invalidExc` and all four flags read 0.
- R2: `resValid` is 1 in the cycle after a cycle with `cmpValid`=1 and 0 in the cycle after a cycle with `cmpValid`=0.
- R3: When operand A is less than operand B (both non-NaN), the flags {N,Z,C,V} are {1,0,0,0}.
- R4: When the operands are equal, the flags are {0,1,1,0}. Any pair of zeros is equal, whatever their signs (bits[30:0] all 0).
- R5: When operand A is greater than operand B (both non-NaN), the flags are {0,0,1,0}. ±infinity (exponent all ones, fraction 0) are ordered as the largest magnitudes.
- R6: When either operand is a NaN (exponent bits[30:23] all ones, fraction bits[22:0] nonzero, either sign, quiet or signaling), the flags are {0,0,1,1}.
- R7: With `sigMode`=0 (quiet), `invalidExc` is never raised, for any operands.
- R8: With `sigMode`=1 (signaling), `invalidExc` is 1 in the result cycle exactly when R6 applies, and 0 otherwise.
- R9: `invalidExc` is 0 whenever `resValid` is 0. The flags hold their last result through cycles that follow no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Start a comparison with the present operands |
| sigMode | input | 1 | 1 selects the signaling flavour, 0 the quiet flavour |
| opA | input | 32 | First operand, single precision |
| opB | input | 32 | Second operand, single precision |
| flagN | output | 1 | A less than B |
| flagZ | output | 1 | A equal to B |
| flagC | output | 1 | A greater than or equal to B, or unordered |
| flagV | output | 1 | Unordered result |
| invalidExc | output | 1 | Invalid-operation pulse (signaling flavour with a NaN operand) |
| resValid | output | 1 | Flags and exception belong to a new result |

## Verification
Two functions can fall in the same result cycle: the flag update for an unordered compare and the exception pulse. These two are raised by different pieces of logic. The bench provokes this cycle by sweeping every pair of a set of special and ordinary encodings, with NaNs in both operand positions, under both flavours, with strobes on back-to-back cycles. In each result cycle it judges the flags and the pulse together against an arithmetic model. Idle cycles are inserted between sweeps to confirm that the pulse drops and that the flags hold.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic capture;   // latch a new comparison result
    logic trapEn;    // signaling flavour selected for this comparison
  } fcmpStrobe_t;

  // Condition flag bundle
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } fcmpFlags_t;

  typedef enum logic [1:0] {
    REL_LESS    = 2'd0,
    REL_EQUAL   = 2'd1,
    REL_GREATER = 2'd2,
    REL_UNORD   = 2'd3
  } fcmpRel_e;

  function automatic fcmpFlags_t relToFlags(fcmpRel_e rel);
    fcmpFlags_t f;
    f = '0;
    case (rel)
      REL_LESS:    f.n = 1'b1;
      REL_EQUAL:   begin f.z = 1'b1; f.c = 1'b1; end
      REL_GREATER: f.c = 1'b1;
      default:     begin f.c = 1'b1; f.v = 1'b1; end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              isNan,
  output logic              isZero,
  output logic [WORD_W-1:0] orderKey
);
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             signBit;

  assign signBit  = word[WORD_W-1];
  assign expField = word[MAN_W +: EXP_W];
  assign manField = word[MAN_W-1:0];

  assign isNan  = (&expField) && (|manField);
  assign isZero = ~|word[WORD_W-2:0];

  // Monotonic unsigned key: negatives invert entirely, positives flip sign bit
  assign orderKey = signBit ? ~word : {1'b1, word[WORD_W-2:0]};
endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmpValid,
  input  logic        sigMode,
  output fcmpStrobe_t strobe,
  output logic        resValid
);
  always_comb begin
    strobe         = '0;
    strobe.capture = cmpValid;
    strobe.trapEn  = cmpValid & sigMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= cmpValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |=> resValid);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid |=> !resValid);  // R2
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcmpStrobe_t       strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output fcmpFlags_t        flags,
  output logic              excPulse
);
  logic [1:0]        nanVec;
  logic [1:0]        zeroVec;
  logic [WORD_W-1:0] keyVec [2];
  logic [WORD_W-1:0] wordVec [2];

  assign wordVec[0] = opA;
  assign wordVec[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word     (wordVec[i]),
      .isNan    (nanVec[i]),
      .isZero   (zeroVec[i]),
      .orderKey (keyVec[i])
    );
  end

  logic     unordered;
  fcmpRel_e relNext;

  assign unordered = |nanVec;

  always_comb begin
    if (unordered)                              relNext = REL_UNORD;
    else if ((&zeroVec) || keyVec[0] == keyVec[1]) relNext = REL_EQUAL;
    else if (keyVec[0] < keyVec[1])             relNext = REL_LESS;
    else                                        relNext = REL_GREATER;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      excPulse <= 1'b0;
    end else begin
      excPulse <= strobe.capture & strobe.trapEn & unordered;
      if (strobe.capture) flags <= relToFlags(relNext);
    end
  end

  AST_EXC_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    excPulse |-> $past(strobe.trapEn));  // R7
  AST_EXC_UNORD: assert property (@(posedge clk) disable iff (!rstN)
    excPulse |-> flags.v);  // R8
  AST_UNORD_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    flags.v |-> (flags.c && !flags.n && !flags.z));  // R6
  AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flags.n, flags.z, flags.v}));  // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(flags));  // R9
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpValid,
  input  logic              sigMode,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic              invalidExc,
  output logic              resValid
);
  fcmpStrobe_t strobe;
  fcmpFlags_t  flags;

  fcmp_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmpValid (cmpValid),
    .sigMode  (sigMode),
    .strobe   (strobe),
    .resValid (resValid)
  );

  fcmp_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .flags    (flags),
    .excPulse (invalidExc)
  );

  assign flagN = flags.n;
  assign flagZ = flags.z;
  assign flagC = flags.c;
  assign flagV = flags.v;

  AST_EXC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    invalidExc |-> resValid);  // R9
  AST_QUIET_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !sigMode) |=> !invalidExc);  // R7
endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpValid = 1'b0;
  logic        sigMode = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        flagN, flagZ, flagC, flagV, invalidExc, resValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_unit u_fcmp_unit (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .sigMode(sigMode),
    .opA(opA), .opB(opB), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV), .invalidExc(invalidExc), .resValid(resValid)
  );

  logic [31:0] vals [16];

  function automatic bit isNanW(logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  // Expected {N,Z,C,V} from sign-magnitude arithmetic
  function automatic logic [3:0] refFlags(logic [31:0] a, logic [31:0] b);
    int rel; // -1 less, 0 equal, 1 greater
    if (isNanW(a) || isNanW(b)) return 4'b0011;
    if (a[30:0] == 0 && b[30:0] == 0) rel = 0;
    else if (a[31] != b[31]) rel = a[31] ? -1 : 1;
    else if (a[30:0] == b[30:0]) rel = 0;
    else if (!a[31]) rel = (a[30:0] < b[30:0]) ? -1 : 1;
    else rel = (a[30:0] > b[30:0]) ? -1 : 1;
    if (rel < 0) return 4'b1000;
    if (rel == 0) return 4'b0110;
    return 4'b0010;
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b (A=%h B=%h mode=%b)",
               req, act, exp, opA, opB, sigMode);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [3:0] lastFlags;
    logic [3:0] expF;
    vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
    vals[2]  = 32'h0000_0001; vals[3]  = 32'h8000_0001;
    vals[4]  = 32'h3F80_0000; vals[5]  = 32'hBF80_0000;
    vals[6]  = 32'h4000_0000; vals[7]  = 32'hC000_0000;
    vals[8]  = 32'h7F7F_FFFF; vals[9]  = 32'hFF7F_FFFF;
    vals[10] = 32'h7F80_0000; vals[11] = 32'hFF80_0000;
    vals[12] = 32'h7FC0_0000; vals[13] = 32'h7F80_0001;
    vals[14] = 32'hFFC0_0000; vals[15] = 32'h3F80_0001;

    repeat (3) @(negedge clk);
    check("R1 reset", {flagN, flagZ, flagC, flagV, invalidExc}, 5'b0);
    check("R1 reset valid", {4'b0, resValid}, 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {flagN, flagZ, flagC, flagV, resValid}, 5'b0);
    lastFlags = 4'b0;

    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          cmpValid = 1'b1;
          sigMode = m[0];
          opA = vals[i];
          opB = vals[j];
          expF = refFlags(vals[i], vals[j]);
          @(negedge clk);
          check("R2 valid", {4'b0, resValid}, 5'b1);
          case (expF)
            4'b1000: check("R3 less", {flagN, flagZ, flagC, flagV, 1'b0}, {expF, 1'b0});
            4'b0110: check("R4 equal", {flagN, flagZ, flagC, flagV, 1'b0}, {expF, 1'b0});
            4'b0010: check("R5 greater", {flagN, flagZ, flagC, flagV, 1'b0}, {expF, 1'b0});
            default: check("R6 unordered", {flagN, flagZ, flagC, flagV, 1'b0}, {expF, 1'b0});
          endcase
          if (m == 0) check("R7 quiet exc", {4'b0, invalidExc}, 5'b0);
          else        check("R8 signal exc", {4'b0, invalidExc}, {4'b0, expF[0]});
          lastFlags = expF;
        end
        // idle cycle after each row: pulse drops, flags hold
        cmpValid = 1'b0;
        opA = 32'h7FC0_0000;
        opB = 32'h0;
        sigMode = 1'b1;
        @(negedge clk);
        check("R2 idle valid", {4'b0, resValid}, 5'b0);
        check("R9 hold", {flagN, flagZ, flagC, flagV, invalidExc}, {lastFlags, 1'b0});
      end
    end
    finish();
  end
endmodule